// File: doc/BRIEF.md
# Segmented DAC Switch-Control Encoder

This block sits in front of a segmented current-steering converter. It takes a binary sample code and cuts it into two fields. The upper field is decoded into a thermometer word that drives a row of equal unit current cells. The lower field is passed on unchanged as binary weights for a small binary-weighted segment.

Alongside these two words, the block produces a one-hot steering select. This select marks the lowest unit cell that is still switched off, and that cell supplies the current for the binary segment. Routing the binary segment's current this way keeps the transfer curve monotonic where the upper field steps. When the upper field is at full scale, every unit cell is already on, so the select moves to one extra spare position.

All three control words are captured in one shared register and leave the block on the same clock edge. This limits the glitch caused by skew between switches, which is worst at transitions such as a mid-scale carry. The widths of the two fields are parameters. The defaults are a 4-bit thermometer field, which gives 15 unit cells and a 16-position select, and a 4-bit binary field.

Top module: `segdac_encoder`

## Requirements
- R1: The binary output equals the low `LSB_W` bits of the code applied one cycle earlier.
- R2: The thermometer output has exactly `m` bits set, where `m` is the upper `MSB_W` bits of the code. The set bits are bits 0 to m-1, so a higher code only adds cells above the ones already on.
- R3: The steering select has exactly one bit set, at index `m`. For the full-scale upper field (m = 2^MSB_W - 1), this is the spare top position 2^MSB_W - 1.
- R4: All outputs update together, exactly one clock edge after the code is presented. Until that edge they hold their previous values, including across the mid-scale carry from 0111... to 1000....
- R5: A synchronous active-high reset drives the all-off state on the next edge: thermometer all zeros, binary all zeros, and the select equal to 1 (bit 0 set).
- R6: While reset is high, the outputs stay in the all-off state whatever code is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | MSB_W+LSB_W | Binary sample code |
| therm_out | output | 2^MSB_W-1 | Unit-cell switch controls, bit i drives cell i |
| bin_out | output | LSB_W | Binary-weighted segment switch controls |
| steer_sel | output | 2^MSB_W | One-hot select of the first off cell (top bit is the spare) |

## Verification
The bench builds the encoder with its default 4+4 split. At this size the full space of 256 codes can be swept, so every thermometer length from empty to full is checked. The full sweep also covers the spare select position and each binary value under each upper field. Directed sequences check the mid-scale carry from 0x7F to 0x80 and the full-scale to zero swing. These sequences confirm that the old outputs hold until the capture edge and then all change together. Further directed cases check that reset holds the all-off state against live input codes.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    localparam int unsigned DEF_MSB_W = 4;
    localparam int unsigned DEF_LSB_W = 4;

    // Number of unit cells driven by the thermometer field
    function automatic int unsigned unit_cells(input int unsigned msb_w);
        return (1 << msb_w) - 1;
    endfunction

    // Switch-control lines: unit cells plus binary cells
    function automatic int unsigned ctrl_lines(input int unsigned msb_w,
                                               input int unsigned lsb_w);
        return unit_cells(msb_w) + lsb_w;
    endfunction

    // Width of the shared output register: control lines plus steering select
    function automatic int unsigned reg_width(input int unsigned msb_w,
                                              input int unsigned lsb_w);
        return ctrl_lines(msb_w, lsb_w) + (1 << msb_w);
    endfunction

endpackage

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
    parameter int unsigned MSB_W = 4,
    localparam int unsigned CELLS = (1 << MSB_W) - 1
) (
    input  logic [MSB_W-1:0] msb_field,
    output logic [CELLS-1:0] therm
);
    // Cell i is on when the field value exceeds i
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        always_comb therm[i] = (int'(msb_field) > i);
    end
endmodule

// File: rtl/segdac_first_off.sv
module segdac_first_off #(
    parameter int unsigned MSB_W = 4,
    localparam int unsigned CELLS = (1 << MSB_W) - 1,
    localparam int unsigned SEL_W = 1 << MSB_W
) (
    input  logic [CELLS-1:0] therm,
    output logic [SEL_W-1:0] sel
);
    // Edge detect on the thermometer with a forced 1 below and 0 above
    logic [SEL_W:0] ext;
    always_comb ext = {1'b0, therm, 1'b1};

    for (genvar i = 0; i < SEL_W; i++) begin : g_pos
        always_comb sel[i] = ext[i] & ~ext[i+1];
    end
endmodule

// File: rtl/segdac_out_reg.sv
module segdac_out_reg #(
    parameter int unsigned MSB_W = 4,
    parameter int unsigned LSB_W = 4,
    localparam int unsigned CELLS = (1 << MSB_W) - 1,
    localparam int unsigned SEL_W = 1 << MSB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CELLS-1:0] therm_d,
    input  logic [LSB_W-1:0] bin_d,
    input  logic [SEL_W-1:0] sel_d,
    output logic [CELLS-1:0] therm_q,
    output logic [LSB_W-1:0] bin_q,
    output logic [SEL_W-1:0] sel_q
);
    typedef struct packed {
        logic [CELLS-1:0] therm;
        logic [LSB_W-1:0] bin;
        logic [SEL_W-1:0] sel;
    } ctrl_word_t;

    localparam ctrl_word_t ALL_OFF = '{therm: '0, bin: '0, sel: SEL_W'(1)};

    ctrl_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) word_q <= ALL_OFF;
        else     word_q <= '{therm: therm_d, bin: bin_d, sel: sel_d};
    end

    always_comb begin
        therm_q = word_q.therm;
        bin_q   = word_q.bin;
        sel_q   = word_q.sel;
    end

    // R6: reset held for two edges keeps all-off state
    p_reset_hold_r6: assert property (@(posedge clk)
        rst && $past(rst) |-> (word_q == ALL_OFF));

    // R4: every output field follows its input of the previous cycle
    p_common_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (therm_q == $past(therm_d)) && (bin_q == $past(bin_d))
                        && (sel_q == $past(sel_d)));
endmodule

// File: rtl/segdac_encoder.sv
module segdac_encoder
    import segdac_pkg::*;
#(
    parameter int unsigned MSB_W = DEF_MSB_W,
    parameter int unsigned LSB_W = DEF_LSB_W,
    localparam int unsigned CODE_W = MSB_W + LSB_W,
    localparam int unsigned CELLS = unit_cells(MSB_W),
    localparam int unsigned SEL_W = 1 << MSB_W,
    localparam int unsigned REG_W = reg_width(MSB_W, LSB_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic [CELLS-1:0]  therm_out,
    output logic [LSB_W-1:0]  bin_out,
    output logic [SEL_W-1:0]  steer_sel
);
    logic [MSB_W-1:0] msb_field;
    logic [LSB_W-1:0] lsb_field;
    logic [CELLS-1:0] therm_d;
    logic [SEL_W-1:0] sel_d;

    always_comb begin
        msb_field = code_in[CODE_W-1:LSB_W];
        lsb_field = code_in[LSB_W-1:0];
    end

    segdac_thermo #(.MSB_W(MSB_W)) u_thermo (
        .msb_field(msb_field),
        .therm    (therm_d)
    );

    segdac_first_off #(.MSB_W(MSB_W)) u_first_off (
        .therm(therm_d),
        .sel  (sel_d)
    );

    segdac_out_reg #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_out_reg (
        .clk    (clk),
        .rst    (rst),
        .therm_d(therm_d),
        .bin_d  (lsb_field),
        .sel_d  (sel_d),
        .therm_q(therm_out),
        .bin_q  (bin_out),
        .sel_q  (steer_sel)
    );

    // Register width is consistent with the package arithmetic
    initial begin
        assert (REG_W == CELLS + LSB_W + SEL_W);
    end

    // R3: select is one-hot at all times out of reset
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(steer_sel) == 1);

    // R3: select sits at the index equal to the number of cells on
    p_sel_position_r3: assert property (@(posedge clk) disable iff (rst)
        (steer_sel >> $countones(therm_out)) == SEL_W'(1));

    // R2: thermometer has no holes (set bits contiguous from bit 0)
    p_therm_contig_r2: assert property (@(posedge clk) disable iff (rst)
        (therm_out & (therm_out + CELLS'(1))) == '0);

    // R2: cells on equal the upper field one cycle earlier
    p_therm_count_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(therm_out) == int'($past(msb_field)));

    // R1: binary field passes through with one cycle of delay
    p_bin_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> bin_out == $past(lsb_field));
endmodule

// File: tb/segdac_encoder_bench.sv
module segdac_encoder_bench;
    localparam int unsigned MSB_W = 4;
    localparam int unsigned LSB_W = 4;
    localparam int unsigned CODE_W = MSB_W + LSB_W;
    localparam int unsigned CELLS = (1 << MSB_W) - 1;
    localparam int unsigned SEL_W = 1 << MSB_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CODE_W-1:0] code_in = '0;
    logic [CELLS-1:0]  therm_out;
    logic [LSB_W-1:0]  bin_out;
    logic [SEL_W-1:0]  steer_sel;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    segdac_encoder #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_segdac_encoder (
        .clk(clk), .rst(rst), .code_in(code_in),
        .therm_out(therm_out), .bin_out(bin_out), .steer_sel(steer_sel)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check all three outputs against a code's expected encoding
    task automatic check_code(input int c, input string tag);
        int m = c >> LSB_W;
        int l = c & ((1 << LSB_W) - 1);
        logic [CELLS-1:0] e_th = CELLS'((64'(1) << m) - 1);
        logic [SEL_W-1:0] e_sel = SEL_W'(64'(1) << m);
        check(therm_out == e_th, {"R2 ", tag}, 64'(therm_out), 64'(e_th));
        check(bin_out == LSB_W'(l), {"R1 ", tag}, 64'(bin_out), 64'(l));
        check(steer_sel == e_sel, {"R3 ", tag}, 64'(steer_sel), 64'(e_sel));
    endtask

    task automatic check_all_off(input string req);
        check(therm_out == '0, req, 64'(therm_out), 64'(0));
        check(bin_out == '0, req, 64'(bin_out), 64'(0));
        check(steer_sel == SEL_W'(1), req, 64'(steer_sel), 64'(1));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        // R5: reset state
        repeat (2) @(negedge clk);
        check_all_off("R5 reset state");

        // R6: reset holds all-off against live codes
        code_in = 8'hB6;
        @(negedge clk);
        check_all_off("R6 reset with code B6");
        code_in = 8'hFF;
        @(negedge clk);
        check_all_off("R6 reset with code FF");

        rst = 1'b0;
        code_in = 8'h00;
        @(negedge clk);

        // R1 R2 R3: exhaustive sweep, one cycle latency
        for (int c = 0; c < (1 << CODE_W); c++) begin
            code_in = CODE_W'(c);
            @(negedge clk);
            check_code(c, "sweep");
        end

        // R4: mid-scale carry, old value held until the edge
        code_in = 8'h7F;
        @(negedge clk);
        code_in = 8'h80;
        @(posedge clk);
        // preponed sample of this edge still shows 7F; check just before next
        #1;
        check_code(8'h80, "R4 carry after edge");
        @(negedge clk);
        code_in = 8'h00;
        #1;
        check_code(8'h80, "R4 hold before edge");
        @(negedge clk);
        check_code(8'h00, "R4 full drop");

        // R4: full-scale swing and back
        code_in = 8'hFF;
        @(negedge clk);
        check_code(8'hFF, "R4 full scale spare");
        code_in = 8'h0F;
        @(negedge clk);
        check_code(8'h0F, "R4 lsb only");

        // R5: reset mid-stream returns to all-off next edge
        code_in = 8'hA5;
        rst = 1'b1;
        @(negedge clk);
        check_all_off("R5 reset mid-stream");
        rst = 1'b0;
        @(negedge clk);
        check_code(8'hA5, "R1 after reset release");

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule